// File: doc/BRIEF.md
# Routed Sixteen-Source Interrupt Controller

This block collects sixteen interrupt sources into two interrupt output lines. Each source keeps a pending bit. Software can force that bit on or off through a pair of write-one registers. Hardware can also set it, either on a rising edge of the raw input or for as long as the raw input is high, as chosen per source. A second pair of write-one registers builds an enable mask. A routing register decides, for each source, whether it is delivered at all and, if so, on which of the two lines it appears.

Source bits 0 to 7 carry the controller's internal events: general timer, watchdog timer, method, context switch, halt, external error, software event 0 and software event 1. Bits 8 to 15 carry external requests. All sixteen bits behave in the same way.

The register port is a plain 32-bit bus with no handshake. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. Raw inputs are synchronous to `clk`. One extra address returns a single bit that shows whether either output line is asserted.

Top module: `irq_router_ctrl`

## Requirements
- R1: After reset, every pending bit, every mask bit, both routing fields and every mode bit read as 0, and both output lines are low.
- R2: A write to offset 0x00 makes pending every source whose data bit is 1, visible at status offset 0x08 on the next cycle. Data bits that are 0 change nothing.
- R3: A write to offset 0x04 clears the pending bit of every edge-mode source whose data bit is 1. Data bits that are 0 change nothing.
- R4: In edge mode (mode bit 0), a raw input that is 0 in one cycle and 1 in the next makes that source pending from the following cycle. The bit stays pending after the input falls, until it is cleared through offset 0x04.
- R5: When a rising edge and a clear write reach the same source in the same cycle, the source stays pending.
- R6: The mode register at offset 0x0C is read/write, and a 1 selects level mode. In level mode, status shows the raw input OR a software-set bit, without delay. A clear write drops only the software-set bit. A rising edge stores nothing.
- R7: A write to offset 0x10 sets mask bits and a write to offset 0x14 clears mask bits, both for data bits that are 1. Offset 0x18 returns the mask. An unmasked source drives no output.
- R8: Routing offset 0x1C is read/write. Bits 0 to 15 are per-source delivery enables, and a source whose enable bit is 0 drives no output.
- R9: A source that is pending, masked in and enabled drives `irq_out_a` when its select bit (bit 16 + source index) is 0, and drives `irq_out_b` when that bit is 1. The output changes in the same cycle as the pending state.
- R10: Offset 0x20 reads bit 0 as the OR of the two output lines, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_raw | input | 16 | Raw source inputs, synchronous to clk |
| irq_out_a | output | 1 | Interrupt line A |
| irq_out_b | output | 1 | Interrupt line B |

## Verification
A wrong pending bit shows at status offset 0x08 one cycle after the write or edge that caused it. Once that source is masked in and routed, it also shows on an output line and at offset 0x20 in the same cycle. A stuck mask or routing bit appears only when a pending source crosses it, so each mask and routing path is tried with its own source. A level-mode error shows without delay, because status follows the raw input combinationally.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int NSRC = 16;
  localparam int DW   = 32;
  localparam int AW   = 8;

  typedef enum logic [7:0] {
    OFF_PSET  = 8'h00,
    OFF_PCLR  = 8'h04,
    OFF_STAT  = 8'h08,
    OFF_MODE  = 8'h0C,
    OFF_MSET  = 8'h10,
    OFF_MCLR  = 8'h14,
    OFF_MASK  = 8'h18,
    OFF_ROUTE = 8'h1C,
    OFF_AGG   = 8'h20
  } reg_off_e;

  typedef struct packed {
    logic pset;
    logic pclr;
    logic mode;
    logic mset;
    logic mclr;
    logic route;
  } wr_strobe_t;
endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int D_W   = DW,
  parameter int A_W   = AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   bus_addr,
  input  logic             bus_we,
  input  logic [D_W-1:0]   bus_wdata,
  output logic [N_SRC-1:0] pset_bits,
  output logic [N_SRC-1:0] pclr_bits,
  output logic [N_SRC-1:0] mode_q,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] route_en_q,
  output logic [N_SRC-1:0] route_sel_q
);
  localparam int SEL_LSB = D_W / 2;

  wr_strobe_t         stb;
  logic [N_SRC-1:0]   wbits;

  assign wbits = bus_wdata[N_SRC-1:0];

  always_comb begin
    stb       = '0;
    stb.pset  = bus_we && (bus_addr == OFF_PSET);
    stb.pclr  = bus_we && (bus_addr == OFF_PCLR);
    stb.mode  = bus_we && (bus_addr == OFF_MODE);
    stb.mset  = bus_we && (bus_addr == OFF_MSET);
    stb.mclr  = bus_we && (bus_addr == OFF_MCLR);
    stb.route = bus_we && (bus_addr == OFF_ROUTE);
  end

  assign pset_bits = stb.pset ? wbits : '0;
  assign pclr_bits = stb.pclr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= '0;
      mask_q      <= '0;
      route_en_q  <= '0;
      route_sel_q <= '0;
    end else begin
      if (stb.mode) mode_q <= wbits;
      if (stb.mset) mask_q <= mask_q | wbits;
      else if (stb.mclr) mask_q <= mask_q & ~wbits;
      if (stb.route) begin
        route_en_q  <= wbits;
        route_sel_q <= bus_wdata[SEL_LSB +: N_SRC];
      end
    end
  end
endmodule

// File: rtl/irq_rt_pend.sv
module irq_rt_pend #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raw,
  input  logic [N_SRC-1:0] mode,
  input  logic [N_SRC-1:0] pset,
  input  logic [N_SRC-1:0] pclr,
  output logic [N_SRC-1:0] pend
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic prev_q;
    logic sw_q;
    logic rise;

    assign rise = raw[i] & ~prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        sw_q   <= 1'b0;
      end else begin
        prev_q <= raw[i];
        if (pset[i]) sw_q <= 1'b1;
        else if (!mode[i] && rise) sw_q <= 1'b1;
        else if (pclr[i]) sw_q <= 1'b0;
      end
    end

    assign pend[i] = mode[i] ? (raw[i] | sw_q) : sw_q;
  end
endmodule

// File: rtl/irq_rt_deliver.sv
module irq_rt_deliver #(
  parameter int N_SRC = 16
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] mask,
  input  logic [N_SRC-1:0] route_en,
  input  logic [N_SRC-1:0] route_sel,
  output logic             irq_a,
  output logic             irq_b
);
  localparam int NLINE = 2;

  logic [N_SRC-1:0] live;
  logic [NLINE-1:0] line;

  assign live = pend & mask & route_en;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [N_SRC-1:0] pick;
    assign pick    = (l == 0) ? ~route_sel : route_sel;
    assign line[l] = |(live & pick);
  end

  assign irq_a = line[0];
  assign irq_b = line[1];
endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_rt_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int D_W   = DW,
  parameter int A_W   = AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   bus_addr,
  input  logic             bus_we,
  input  logic [D_W-1:0]   bus_wdata,
  output logic [D_W-1:0]   bus_rdata,
  input  logic [N_SRC-1:0] irq_raw,
  output logic             irq_out_a,
  output logic             irq_out_b
);
  localparam int SEL_LSB = D_W / 2;

  logic [N_SRC-1:0] pset_bits, pclr_bits;
  logic [N_SRC-1:0] mode_q, mask_q, route_en_q, route_sel_q;
  logic [N_SRC-1:0] pend_vec;

  irq_rt_regs #(.N_SRC(N_SRC), .D_W(D_W), .A_W(A_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .pset_bits  (pset_bits),
    .pclr_bits  (pclr_bits),
    .mode_q     (mode_q),
    .mask_q     (mask_q),
    .route_en_q (route_en_q),
    .route_sel_q(route_sel_q)
  );

  irq_rt_pend #(.N_SRC(N_SRC)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (irq_raw),
    .mode (mode_q),
    .pset (pset_bits),
    .pclr (pclr_bits),
    .pend (pend_vec)
  );

  irq_rt_deliver #(.N_SRC(N_SRC)) u_deliver (
    .pend     (pend_vec),
    .mask     (mask_q),
    .route_en (route_en_q),
    .route_sel(route_sel_q),
    .irq_a    (irq_out_a),
    .irq_b    (irq_out_b)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_STAT:  bus_rdata[N_SRC-1:0] = pend_vec;
      OFF_MODE:  bus_rdata[N_SRC-1:0] = mode_q;
      OFF_MASK:  bus_rdata[N_SRC-1:0] = mask_q;
      OFF_ROUTE: begin
        bus_rdata[N_SRC-1:0]       = route_en_q;
        bus_rdata[SEL_LSB +: N_SRC] = route_sel_q;
      end
      OFF_AGG:   bus_rdata[0] = irq_out_a | irq_out_b;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_rt_checker.sv
module irq_rt_checker
  import irq_rt_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int D_W   = DW,
  parameter int A_W   = AW
) (
  input logic             clk,
  input logic             rst_n,
  input logic [A_W-1:0]   bus_addr,
  input logic             bus_we,
  input logic [D_W-1:0]   bus_wdata,
  input logic [D_W-1:0]   bus_rdata,
  input logic [N_SRC-1:0] irq_raw,
  input logic             irq_out_a,
  input logic             irq_out_b,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] mode,
  input logic [N_SRC-1:0] mask,
  input logic [N_SRC-1:0] route_en
);
  logic [N_SRC-1:0] raw_prev;
  logic [N_SRC-1:0] edge_v;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_prev <= '0;
    else        raw_prev <= irq_raw;
  end
  assign edge_v = irq_raw & ~raw_prev & ~mode;

  AST_PSET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_PSET) |=> ((pend & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]))); // R2
  AST_PCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_PCLR) |=> ((pend & $past(bus_wdata[N_SRC-1:0] & ~mode & ~edge_v)) == '0)); // R3
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v != '0) |=> ((pend & $past(edge_v)) == $past(edge_v))); // R5
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mode & irq_raw) == (mode & irq_raw))); // R6
  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (!irq_out_a && !irq_out_b)); // R7
  AST_UNROUTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (route_en == '0) |-> (!irq_out_a && !irq_out_b)); // R8
  AST_AGG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_AGG) |-> (bus_rdata == {{(D_W-1){1'b0}}, irq_out_a | irq_out_b})); // R10
endmodule

bind irq_router_ctrl irq_rt_checker #(.N_SRC(N_SRC), .D_W(D_W), .A_W(A_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_raw  (irq_raw),
  .irq_out_a(irq_out_a),
  .irq_out_b(irq_out_b),
  .pend     (pend_vec),
  .mode     (mode_q),
  .mask     (mask_q),
  .route_en (route_en_q)
);

// File: tb/irq_router_ctrl_bench.sv
module irq_router_ctrl_bench;
  localparam logic [7:0] A_PSET = 8'h00, A_PCLR = 8'h04, A_STAT = 8'h08, A_MODE = 8'h0C;
  localparam logic [7:0] A_MSET = 8'h10, A_MCLR = 8'h14, A_MASK = 8'h18, A_ROUTE = 8'h1C, A_AGG = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic [15:0] raw = '0;
  logic        out_a, out_b;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5ns clk = ~clk;

  irq_router_ctrl u_irq_router_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rdata), .irq_raw(raw), .irq_out_a(out_a), .irq_out_b(out_b)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1ns; v = rdata;
  endtask

  task automatic outs(output logic [31:0] v);
    @(negedge clk); #1ns; v = {30'd0, out_b, out_a};
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v);  chk("R1 status", v, 32'h0);
    rd(A_MASK, v);  chk("R1 mask", v, 32'h0);
    rd(A_MODE, v);  chk("R1 mode", v, 32'h0);
    rd(A_ROUTE, v); chk("R1 route", v, 32'h0);
    outs(v);        chk("R1 outputs", v, 32'h0);
  endtask

  task automatic t_set_clr;
    logic [31:0] v;
    wr(A_PSET, 32'h00A5); rd(A_STAT, v); chk("R2 set", v, 32'h00A5);
    wr(A_PSET, 32'h0000); rd(A_STAT, v); chk("R2 zero set", v, 32'h00A5);
    wr(A_PCLR, 32'h0005); rd(A_STAT, v); chk("R3 clear", v, 32'h00A0);
    wr(A_PCLR, 32'h0000); rd(A_STAT, v); chk("R3 zero clear", v, 32'h00A0);
    wr(A_PCLR, 32'hFFFF); rd(A_STAT, v); chk("R3 clear all", v, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    @(negedge clk); raw[9] = 1'b1;
    rd(A_STAT, v); chk("R4 edge sets", v, 32'h0200);
    @(negedge clk); raw[9] = 1'b0;
    rd(A_STAT, v); chk("R4 sticky", v, 32'h0200);
    @(negedge clk); raw[9] = 1'b1;
    rd(A_STAT, v);
    wr(A_PCLR, 32'h0200); rd(A_STAT, v); chk("R4 clear while high", v, 32'h0);
    @(negedge clk); raw[9] = 1'b0;
  endtask

  task automatic t_edge_vs_clr;
    logic [31:0] v;
    wr(A_PSET, 32'h0008);
    @(negedge clk); raw[3] = 1'b1; addr = A_PCLR; we = 1'b1; wd = 32'h0008;
    @(negedge clk); we = 1'b0; wd = '0;
    rd(A_STAT, v); chk("R5 edge beats clear", v, 32'h0008);
    @(negedge clk); raw[3] = 1'b0;
    wr(A_PCLR, 32'h0008); rd(A_STAT, v); chk("R5 cleared later", v, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(A_MODE, 32'h0001); rd(A_MODE, v); chk("R6 mode readback", v, 32'h0001);
    @(negedge clk); raw[0] = 1'b1; addr = A_STAT; #1ns;
    chk("R6 follows raw", rdata, 32'h0001);
    wr(A_PCLR, 32'h0001); rd(A_STAT, v); chk("R6 clear held by raw", v, 32'h0001);
    @(negedge clk); raw[0] = 1'b0; addr = A_STAT; #1ns;
    chk("R6 drops with raw", rdata, 32'h0);
    wr(A_PSET, 32'h0001); rd(A_STAT, v); chk("R6 sw set", v, 32'h0001);
    wr(A_PCLR, 32'h0001); rd(A_STAT, v); chk("R6 sw clear", v, 32'h0);
    wr(A_MODE, 32'h0000);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(A_MSET, 32'h0F0F); rd(A_MASK, v); chk("R7 mask set", v, 32'h0F0F);
    wr(A_MSET, 32'h0000); rd(A_MASK, v); chk("R7 zero set", v, 32'h0F0F);
    wr(A_MCLR, 32'h0003); rd(A_MASK, v); chk("R7 mask clear", v, 32'h0F0C);
    wr(A_MCLR, 32'hFFFF); rd(A_MASK, v); chk("R7 mask clear all", v, 32'h0);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr(A_MSET, 32'hFFFF);
    wr(A_ROUTE, 32'h0004_0006); rd(A_ROUTE, v); chk("R8 route readback", v, 32'h0004_0006);
    wr(A_PSET, 32'h0002); outs(v); chk("R9 line A", v, 32'h1);
    rd(A_AGG, v); chk("R10 agg on A", v, 32'h1);
    wr(A_PCLR, 32'h0002); wr(A_PSET, 32'h0004); outs(v); chk("R9 line B", v, 32'h2);
    rd(A_AGG, v); chk("R10 agg on B", v, 32'h1);
    wr(A_MCLR, 32'h0004); outs(v); chk("R7 masked off", v, 32'h0);
    wr(A_PCLR, 32'h0004); wr(A_PSET, 32'h0020); outs(v); chk("R8 not enabled", v, 32'h0);
    rd(A_AGG, v); chk("R10 agg idle", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clr();
    t_edge();
    t_edge_vs_clr();
    t_level();
    t_mask();
    t_route();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule